// File: doc/BRIEF.md
# Sliced-State Multi-Pattern Byte Matcher

This block finds every occurrence of up to sixteen fixed byte strings in a continuous payload stream. It takes one byte per clock. The byte is cut into four 2-bit slices, and each slice drives its own small state tile. A tile is a state machine that follows only its two bits of every byte. Each tile has its own transition table: four next-state pointers per state, one for each slice value. Each state also holds a 16-bit partial vector. Bit p of that vector says that, as far as this tile's bits can tell, pattern p may end here.

A pattern is reported only when all four tiles agree. The full result is the bitwise AND of the four partial vectors, taken through an output register. A set bit means that pattern ends at the byte that produced the result. Patterns may start anywhere in the stream. Several of these blocks can run side by side on the same stream, each loaded with its own subset of patterns. Their result vectors are then concatenated into one wide match vector.

The tables are loaded through a write port. Each write names a tile, a state address and a whole table entry. The automata are built outside this block.

Top module: `bitsplit_match_engine`

## Requirements
- R1: Tile k (k = 0..3) is driven by byte bits [2k+1:2k]. With tables built per slice, a byte raises exactly the patterns whose value equals that byte.
- R2: The result vector is the bitwise AND of the four partial vectors. A pattern bit is set only when every tile reports it for the same byte.
- R3: A byte accepted at clock edge n gives its result, with out_valid high, just after edge n+1. out_valid is in_valid delayed by two edges.
- R4: While in_valid is low, every tile keeps its current state, and the next result slot has out_valid low and out_match all zero.
- R5: A write with cfg_we high stores cfg_data at entry cfg_addr of tile cfg_tile and no other tile. In an entry, bits [15:0] are the partial vector, and bits [16+5v +: 5] are the next state for slice value v.
- R6: Reset is synchronous and active high. It puts every tile in state 0 and drives out_valid and out_match to zero. Table contents are not cleared.
- R7: A new byte is accepted on every clock with no stall. The latency does not depend on the data.
- R8: On a valid byte, each tile moves to the next state its current entry gives for its slice value. The partial vector used is the one stored at the state reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_byte this cycle |
| in_byte | input | 8 | Payload byte |
| cfg_we | input | 1 | Table write strobe |
| cfg_tile | input | 2 | Tile selected by the write |
| cfg_addr | input | 5 | State entry written |
| cfg_data | input | 36 | Entry: partial vector in [15:0], four 5-bit next pointers above it |
| out_valid | output | 1 | Result slot holds a byte's result |
| out_match | output | 16 | Patterns ending at that byte |

## Verification
The checker tests these on every cycle:
- the two-edge valid delay;
- that idle cycles hold the tile states and return an all-zero result;
- that the reset state is correct;
- that a write reaches exactly one tile;
- that every reported bit was present in each tile's partial vector one cycle earlier.

Whether the right patterns are found can only be shown by the bench scenarios. In one, tables built per slice are compared against a plain byte-equality rule. In another, random tables are walked by a reference model, with idle gaps in the stream and with entries rewritten partway through.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int DEF_SLICE_W = 2;
  localparam int DEF_N_TILES = 4;
  localparam int DEF_STATE_W = 5;
  localparam int DEF_PMV_W   = 16;

  // width of one table entry: partial vector plus one pointer per slice value
  function automatic int entry_width(input int pmv_w, input int slice_w, input int state_w);
    return pmv_w + (1 << slice_w) * state_w;
  endfunction
endpackage

// File: rtl/bsm_tile.sv
module bsm_tile #(
  parameter int SLICE_W = bsm_pkg::DEF_SLICE_W,
  parameter int STATE_W = bsm_pkg::DEF_STATE_W,
  parameter int PMV_W   = bsm_pkg::DEF_PMV_W,
  localparam int N_STATES = 1 << STATE_W,
  localparam int ENTRY_W  = bsm_pkg::entry_width(PMV_W, SLICE_W, STATE_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_en,
  input  logic [SLICE_W-1:0] slice,
  input  logic               wr_en,
  input  logic [STATE_W-1:0] wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic [STATE_W-1:0] state_o,
  output logic [PMV_W-1:0]   pmv_o
);
  logic [ENTRY_W-1:0] table_q [N_STATES];
  logic [STATE_W-1:0] state_q;
  logic [PMV_W-1:0]   pmv_q;
  logic [STATE_W-1:0] next_state;
  logic [PMV_W-1:0]   next_pmv;

  // table storage: write port only, no reset, so it can map to RAM
  always_ff @(posedge clk) begin
    if (wr_en) table_q[wr_addr] <= wr_data;
  end

  // transition lookup and partial vector of the state reached
  always_comb begin
    next_state = table_q[state_q][PMV_W + int'(slice) * STATE_W +: STATE_W];
    next_pmv   = table_q[next_state][PMV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      pmv_q   <= '0;
    end else if (step_en) begin
      state_q <= next_state;
      pmv_q   <= next_pmv;
    end
  end

  assign state_o = state_q;
  assign pmv_o   = pmv_q;
endmodule

// File: rtl/bsm_combine.sv
module bsm_combine #(
  parameter int N_TILES = bsm_pkg::DEF_N_TILES,
  parameter int PMV_W   = bsm_pkg::DEF_PMV_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     slot_valid,
  input  logic [N_TILES*PMV_W-1:0] pmv_flat,
  output logic                     out_valid,
  output logic [PMV_W-1:0]         out_match
);
  logic [PMV_W-1:0] chain [N_TILES+1];

  assign chain[0] = '1;
  for (genvar t = 0; t < N_TILES; t++) begin : g_and
    assign chain[t+1] = chain[t] & pmv_flat[t*PMV_W +: PMV_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_match <= '0;
    end else begin
      out_valid <= slot_valid;
      out_match <= slot_valid ? chain[N_TILES] : '0;
    end
  end
endmodule

// File: rtl/bitsplit_match_engine.sv
module bitsplit_match_engine #(
  parameter int SLICE_W = bsm_pkg::DEF_SLICE_W,
  parameter int N_TILES = bsm_pkg::DEF_N_TILES,
  parameter int STATE_W = bsm_pkg::DEF_STATE_W,
  parameter int PMV_W   = bsm_pkg::DEF_PMV_W,
  localparam int BYTE_W  = SLICE_W * N_TILES,
  localparam int TILE_IW = (N_TILES > 1) ? $clog2(N_TILES) : 1,
  localparam int ENTRY_W = bsm_pkg::entry_width(PMV_W, SLICE_W, STATE_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [BYTE_W-1:0]  in_byte,
  input  logic               cfg_we,
  input  logic [TILE_IW-1:0] cfg_tile,
  input  logic [STATE_W-1:0] cfg_addr,
  input  logic [ENTRY_W-1:0] cfg_data,
  output logic               out_valid,
  output logic [PMV_W-1:0]   out_match
);
  logic [N_TILES-1:0]         tile_we;
  logic [N_TILES*STATE_W-1:0] st_all;
  logic [N_TILES*PMV_W-1:0]   pmv_all;
  logic                       slot_valid;

  // one byte per cycle; the tile stage result is valid one edge later
  always_ff @(posedge clk) begin
    if (rst) slot_valid <= 1'b0;
    else     slot_valid <= in_valid;
  end

  for (genvar t = 0; t < N_TILES; t++) begin : g_tile
    assign tile_we[t] = cfg_we && (cfg_tile == TILE_IW'(t));

    bsm_tile #(
      .SLICE_W(SLICE_W),
      .STATE_W(STATE_W),
      .PMV_W  (PMV_W)
    ) u_tile (
      .clk    (clk),
      .rst    (rst),
      .step_en(in_valid),
      .slice  (in_byte[t*SLICE_W +: SLICE_W]),
      .wr_en  (tile_we[t]),
      .wr_addr(cfg_addr),
      .wr_data(cfg_data),
      .state_o(st_all[t*STATE_W +: STATE_W]),
      .pmv_o  (pmv_all[t*PMV_W +: PMV_W])
    );
  end

  bsm_combine #(
    .N_TILES(N_TILES),
    .PMV_W  (PMV_W)
  ) u_combine (
    .clk       (clk),
    .rst       (rst),
    .slot_valid(slot_valid),
    .pmv_flat  (pmv_all),
    .out_valid (out_valid),
    .out_match (out_match)
  );
endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
  parameter int N_TILES = 4,
  parameter int STATE_W = 5,
  parameter int PMV_W   = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic                       cfg_we,
  input logic [N_TILES-1:0]         tile_we,
  input logic [N_TILES*STATE_W-1:0] st_all,
  input logic [N_TILES*PMV_W-1:0]   pmv_all,
  input logic                       out_valid,
  input logic [PMV_W-1:0]           out_match
);
  a_r3_valid_delay_hi: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);
  a_r3_valid_delay_lo: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);
  a_r4_state_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(st_all));
  a_r4_quiet_result: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_match == '0));
  a_r6_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st_all == '0 && !out_valid && out_match == '0));
  a_r5_one_tile: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> ($countones(tile_we) == 1));
  a_r5_no_stray: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |-> (tile_we == '0));

  for (genvar t = 0; t < N_TILES; t++) begin : g_sub
    a_r2_all_agree: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ((out_match & ~$past(pmv_all[t*PMV_W +: PMV_W])) == '0));
  end
endmodule

bind bitsplit_match_engine bsm_checker #(
  .N_TILES(N_TILES),
  .STATE_W(STATE_W),
  .PMV_W  (PMV_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .cfg_we   (cfg_we),
  .tile_we  (tile_we),
  .st_all   (st_all),
  .pmv_all  (pmv_all),
  .out_valid(out_valid),
  .out_match(out_match)
);

// File: tb/tb_bitsplit_match_engine.sv
`timescale 1ns/1ps
module tb_bitsplit_match_engine;
  localparam int NT = 4;
  localparam int SW = 5;
  localparam int PW = 16;
  localparam int EW = PW + 4 * SW;
  localparam int NS = 1 << SW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_tile = '0;
  logic [SW-1:0] cfg_addr = '0;
  logic [EW-1:0] cfg_data = '0;
  logic          out_valid;
  logic [PW-1:0] out_match;

  always #4 clk = ~clk;

  bitsplit_match_engine dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .cfg_we(cfg_we), .cfg_tile(cfg_tile), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_match(out_match)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [EW-1:0] ref_tbl [NT][NS];
  int            ref_st [NT];
  logic [7:0]    pat [PW];
  bit            sem_mode = 1'b0;
  bit            e1_v = 1'b0, e2_v = 1'b0;
  logic [PW-1:0] e1_m = '0, e2_m = '0;

  task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock slot: check the result due now, update the model, drive inputs
  task automatic step(input string tag, input bit v, input logic [7:0] b,
                      input bit we, input logic [1:0] t, input logic [SW-1:0] a,
                      input logic [EW-1:0] d);
    logic [PW-1:0] acc;
    logic [PW-1:0] sem;
    @(negedge clk);
    check({tag, " out_valid"}, PW'(out_valid), PW'(e2_v));
    check({tag, " out_match"}, out_match, e2_m);
    e2_v = e1_v;
    e2_m = e1_m;
    acc = '1;
    if (v) begin
      for (int k = 0; k < NT; k++) begin
        int s;
        int ns;
        s = (b >> (2 * k)) & 3;
        ns = int'(ref_tbl[k][ref_st[k]][PW + s * SW +: SW]);
        ref_st[k] = ns;
        acc &= ref_tbl[k][ns][PW-1:0];
      end
    end
    sem = '0;
    for (int p = 0; p < PW; p++) if (b == pat[p]) sem[p] = 1'b1;
    e1_v = v;
    e1_m = v ? (sem_mode ? sem : acc) : '0;
    if (we) ref_tbl[t][a] = d;
    in_valid = v;
    in_byte  = b;
    cfg_we   = we;
    cfg_tile = t;
    cfg_addr = a;
    cfg_data = d;
  endtask

  task automatic feed(input string tag, input bit v, input logic [7:0] b);
    step(tag, v, b, 1'b0, 2'd0, '0, '0);
  endtask

  task automatic wr(input string tag, input logic [1:0] t, input logic [SW-1:0] a,
                    input logic [EW-1:0] d);
    step(tag, 1'b0, 8'h00, 1'b1, t, a, d);
  endtask

  function automatic logic [EW-1:0] rand_entry();
    logic [EW-1:0] e;
    e[PW-1:0] = PW'($urandom | $urandom);
    for (int v = 0; v < 4; v++) e[PW + v * SW +: SW] = SW'($urandom % NS);
    return e;
  endfunction

  initial begin
    for (int p = 0; p < PW; p++) pat[p] = 8'(p * 17) ^ 8'h5A;
    for (int k = 0; k < NT; k++) begin
      ref_st[k] = 0;
      for (int s = 0; s < NS; s++) ref_tbl[k][s] = '0;
    end

    // R6: outputs idle while reset is held
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 reset out_valid", PW'(out_valid), '0);
    check("R6 reset out_match", out_match, '0);
    rst = 1'b0;

    // R5 R1: per-slice tables; state 1+v reached on slice value v from any state
    for (int t = 0; t < NT; t++) begin
      for (int s = 0; s < 5; s++) begin
        logic [EW-1:0] e;
        e = '0;
        for (int v = 0; v < 4; v++) e[PW + v * SW +: SW] = SW'(1 + v);
        if (s > 0)
          for (int p = 0; p < PW; p++)
            if (((pat[p] >> (2 * t)) & 3) == (s - 1)) e[p] = 1'b1;
        wr("R5 load", 2'(t), SW'(s), e);
      end
    end
    sem_mode = 1'b1;
    // R1 R2: every pattern byte, then near misses differing in one slice
    for (int p = 0; p < PW; p++) feed("R1 exact byte", 1'b1, pat[p]);
    for (int p = 0; p < PW; p++)
      for (int k = 0; k < NT; k++)
        feed("R2 one slice differs", 1'b1, pat[p] ^ 8'(1 << (2 * k)));
    for (int i = 0; i < 200; i++) feed("R1 random byte", 1'b1, 8'($urandom));
    for (int i = 0; i < 100; i++) feed("R4 gaps", 1'($urandom % 2), pat[$urandom % PW]);
    feed("R3 drain", 1'b0, 8'h00);
    feed("R3 drain", 1'b0, 8'h00);
    sem_mode = 1'b0;

    // R5: random automata in every tile
    for (int t = 0; t < NT; t++)
      for (int s = 0; s < NS; s++) wr("R5 full load", 2'(t), SW'(s), rand_entry());
    // R7 R8 R3: back-to-back bytes walking the tables
    for (int i = 0; i < 600; i++) feed("R7 R8 stream", 1'b1, 8'($urandom));
    // R4: idle cycles must keep every tile's state
    for (int i = 0; i < 600; i++) feed("R4 hold", 1'(($urandom % 4) != 0), 8'($urandom));
    // R5: rewrite entries of single tiles between bursts
    for (int r = 0; r < 10; r++) begin
      for (int j = 0; j < 3; j++)
        wr("R5 rewrite", 2'($urandom % NT), SW'($urandom % NS), rand_entry());
      for (int i = 0; i < 40; i++) feed("R5 after rewrite", 1'b1, 8'($urandom));
    end
    feed("R3 drain", 1'b0, 8'h00);
    feed("R3 drain", 1'b0, 8'h00);
    feed("R3 drain", 1'b0, 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule